// File: doc/BRIEF.md
# Delayed-Branch Next-PC Unit

This unit sits on the fetch side of a five-stage integer pipeline with a single branch delay slot. It holds the program counter and drives the address that instruction fetch uses in each cycle. A conditional branch is evaluated while it occupies the execute stage. Its operands may come from the register file or from the result of the ALU instruction just ahead of it.

The taken decision and the target address travel combinationally from the comparator to the fetch-address multiplexer in the same cycle. The instruction after the branch is already in decode, so it always executes. The target is fetched next, so no cycle is lost. The tests are deliberately cheap: equality of two operands, or sign and zero checks on one operand. None of them needs carry propagation. The unit never stalls, and it has no hazard interlock.

Top module: `delay_branch_npc`

## Requirements
- R1: While reset is asserted, and in the first cycle after release with no branch presented, `fetchAddr` equals `BOOT_ADDR` (default 32'hBFC0_0000) and `taken` is low.
- R2: In every cycle with no taken branch, `fetchAddr` is the previous cycle's `fetchAddr` plus 4. The unit never holds the address.
- R3: The taken target is the delay-slot address plus the sign-extended 16-bit offset shifted left by two. The delay-slot address is the `fetchAddr` of the cycle before the branch reaches execute.
- R4: A taken branch changes `fetchAddr` in the same cycle it is presented. The following cycle fetches target plus 4, so the order is branch, delay slot, target, with no bubble.
- R5: `brType` 1 is taken when operand A equals operand B, and `brType` 2 is taken when they differ.
- R6: `brType` 3 is taken when operand A is negative (bit 31 set), and `brType` 4 is taken when operand A is zero or positive.
- R7: `brType` 5 is taken when operand A is negative or zero, and `brType` 6 is taken when operand A is positive and nonzero.
- R8: `brType` 0 (no branch) and the unused code 7 never assert `taken`.
- R9: An operand whose index matches a nonzero `prevDest` takes `prevResult` instead of the register-file value when `prevWrEn` is high and `prevIsLoad` is low.
- R10: An operand with index 0 reads as zero, whatever `rsData`/`rtData` or a write to destination 0 presents.
- R11: When `prevIsLoad` is high, `prevResult` is not forwarded and the register-file value is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| brType | input | 3 | Branch class of the instruction in execute (0 none, 1 eq, 2 ne, 3 ltz, 4 gez, 5 lez, 6 gtz, 7 unused) |
| brOffset | input | 16 | Signed word offset of the branch |
| rsIdx | input | 5 | Index of operand A |
| rtIdx | input | 5 | Index of operand B |
| rsData | input | 32 | Register-file value for operand A |
| rtData | input | 32 | Register-file value for operand B |
| prevWrEn | input | 1 | Preceding instruction writes a register |
| prevIsLoad | input | 1 | Preceding instruction is a load |
| prevDest | input | 5 | Destination index of the preceding instruction |
| prevResult | input | 32 | Result of the preceding instruction |
| fetchAddr | output | 32 | Address fetched in this cycle |
| taken | output | 1 | Branch in execute is taken |

## Verification
Some properties are checked on every cycle. Each address step is either plus 4 or the offset-derived target, measured against the previous fetch address. The no-branch codes never fire. A branch comparing a register with itself resolves the only way it can. The boot address appears when reset lifts. Other behaviour is shown only by the bench's scenarios, which compute the expected operand values themselves: each test class against signed data, and forwarding against a matching or mismatching destination. They also cover the zero-register rule and the refusal to forward a load result.

// File: rtl/npc_pkg.sv
package npc_pkg;

  typedef enum logic [2:0] {
    BR_NONE = 3'd0,
    BR_EQ   = 3'd1,
    BR_NE   = 3'd2,
    BR_LTZ  = 3'd3,
    BR_GEZ  = 3'd4,
    BR_LEZ  = 3'd5,
    BR_GTZ  = 3'd6,
    BR_RSVD = 3'd7
  } brKind_t;

  // comparator results, datapath -> control
  typedef struct packed {
    logic eq;
    logic neg;
    logic zero;
  } npcFlags_t;

  // strobes, control -> datapath
  typedef struct packed {
    logic selTarget;
  } npcStrobe_t;

endpackage

// File: rtl/npc_ctrl.sv
module npc_ctrl
  import npc_pkg::*;
(
  input  logic       rstN,
  input  logic [2:0] brType,
  input  npcFlags_t  flags,
  output npcStrobe_t strobe
);

  brKind_t kind;
  logic    cond;

  assign kind = brKind_t'(brType);

  always_comb begin
    unique case (kind)
      BR_EQ:   cond = flags.eq;
      BR_NE:   cond = !flags.eq;
      BR_LTZ:  cond = flags.neg;
      BR_GEZ:  cond = !flags.neg;
      BR_LEZ:  cond = flags.neg || flags.zero;
      BR_GTZ:  cond = !flags.neg && !flags.zero;
      default: cond = 1'b0;
    endcase
  end

  // no redirect while the pipeline is held in reset
  assign strobe.selTarget = rstN && cond;

endmodule

// File: rtl/npc_dpath.sv
module npc_dpath
  import npc_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          DATA_W    = 32,
  parameter int          REG_IDX_W = 5,
  parameter int          OFF_W     = 16,
  parameter logic [31:0] BOOT_ADDR = 32'hBFC0_0000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [OFF_W-1:0]     brOffset,
  input  logic [REG_IDX_W-1:0] rsIdx,
  input  logic [REG_IDX_W-1:0] rtIdx,
  input  logic [DATA_W-1:0]    rsData,
  input  logic [DATA_W-1:0]    rtData,
  input  logic                 prevWrEn,
  input  logic                 prevIsLoad,
  input  logic [REG_IDX_W-1:0] prevDest,
  input  logic [DATA_W-1:0]    prevResult,
  input  npcStrobe_t           strobe,
  output npcFlags_t            flags,
  output logic [ADDR_W-1:0]    fetchAddr
);

  localparam int NUM_SRC = 2;
  localparam int EXT_W   = ADDR_W - OFF_W - 2;
  localparam logic [ADDR_W-1:0] WORD = ADDR_W'(4);

  logic [REG_IDX_W-1:0] srcIdx [NUM_SRC];
  logic [DATA_W-1:0]    srcReg [NUM_SRC];
  logic [DATA_W-1:0]    opVal  [NUM_SRC];

  assign srcIdx[0] = rsIdx;
  assign srcIdx[1] = rtIdx;
  assign srcReg[0] = rsData;
  assign srcReg[1] = rtData;

  // execute-to-execute bypass, one lane per comparator operand
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_byp
    logic isZeroReg;
    logic fwdHit;
    assign isZeroReg = (srcIdx[g] == '0);
    assign fwdHit    = prevWrEn && !prevIsLoad && (prevDest != '0) && (prevDest == srcIdx[g]);
    assign opVal[g]  = isZeroReg ? '0 : (fwdHit ? prevResult : srcReg[g]);
  end

  // only cheap tests: no adder on the decision path
  assign flags.eq   = (opVal[0] == opVal[1]);
  assign flags.neg  = opVal[0][DATA_W-1];
  assign flags.zero = (opVal[0] == '0);

  logic [ADDR_W-1:0] pcReg;
  logic [ADDR_W-1:0] slotAddr;
  logic [ADDR_W-1:0] offExt;
  logic [ADDR_W-1:0] targetAddr;

  // pcReg holds branch+8 while the branch is in execute
  assign slotAddr   = pcReg - WORD;
  assign offExt     = {{EXT_W{brOffset[OFF_W-1]}}, brOffset, 2'b00};
  assign targetAddr = slotAddr + offExt;
  assign fetchAddr  = strobe.selTarget ? targetAddr : pcReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pcReg <= BOOT_ADDR[ADDR_W-1:0];
    else       pcReg <= fetchAddr + WORD;
  end

endmodule

// File: rtl/delay_branch_npc.sv
module delay_branch_npc
  import npc_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          DATA_W    = 32,
  parameter int          REG_IDX_W = 5,
  parameter int          OFF_W     = 16,
  parameter logic [31:0] BOOT_ADDR = 32'hBFC0_0000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [2:0]           brType,
  input  logic [OFF_W-1:0]     brOffset,
  input  logic [REG_IDX_W-1:0] rsIdx,
  input  logic [REG_IDX_W-1:0] rtIdx,
  input  logic [DATA_W-1:0]    rsData,
  input  logic [DATA_W-1:0]    rtData,
  input  logic                 prevWrEn,
  input  logic                 prevIsLoad,
  input  logic [REG_IDX_W-1:0] prevDest,
  input  logic [DATA_W-1:0]    prevResult,
  output logic [ADDR_W-1:0]    fetchAddr,
  output logic                 taken
);

  npcFlags_t  flags;
  npcStrobe_t strobe;

  npc_ctrl u_ctrl (
    .rstN   (rstN),
    .brType (brType),
    .flags  (flags),
    .strobe (strobe)
  );

  npc_dpath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .REG_IDX_W (REG_IDX_W),
    .OFF_W     (OFF_W),
    .BOOT_ADDR (BOOT_ADDR)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .brOffset   (brOffset),
    .rsIdx      (rsIdx),
    .rtIdx      (rtIdx),
    .rsData     (rsData),
    .rtData     (rtData),
    .prevWrEn   (prevWrEn),
    .prevIsLoad (prevIsLoad),
    .prevDest   (prevDest),
    .prevResult (prevResult),
    .strobe     (strobe),
    .flags      (flags),
    .fetchAddr  (fetchAddr)
  );

  assign taken = strobe.selTarget;

endmodule

// File: rtl/npc_checker.sv
module npc_checker #(
  parameter int          ADDR_W    = 32,
  parameter int          REG_IDX_W = 5,
  parameter int          OFF_W     = 16,
  parameter logic [31:0] BOOT_ADDR = 32'hBFC0_0000
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [2:0]           brType,
  input logic [OFF_W-1:0]     brOffset,
  input logic [REG_IDX_W-1:0] rsIdx,
  input logic [REG_IDX_W-1:0] rtIdx,
  input logic [ADDR_W-1:0]    fetchAddr,
  input logic                 taken
);

  localparam int EXT_W = ADDR_W - OFF_W - 2;

  logic              lastValid;
  logic [ADDR_W-1:0] lastFetch;
  logic [ADDR_W-1:0] scaledOff;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastValid <= 1'b0;
      lastFetch <= '0;
    end else begin
      lastValid <= 1'b1;
      lastFetch <= fetchAddr;
    end
  end

  assign scaledOff = {{EXT_W{brOffset[OFF_W-1]}}, brOffset, 2'b00};

  p_boot_addr_r1: assert property (@(posedge clk)
    $rose(rstN) && (brType == 3'd0) |-> fetchAddr == BOOT_ADDR[ADDR_W-1:0]);

  p_seq_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    lastValid && !taken |-> fetchAddr == lastFetch + ADDR_W'(4));

  p_target_r3: assert property (@(posedge clk) disable iff (!rstN)
    lastValid && taken |-> fetchAddr == lastFetch + scaledOff);

  p_self_eq_r5: assert property (@(posedge clk) disable iff (!rstN)
    (brType == 3'd1) && (rsIdx == rtIdx) |-> taken);

  p_self_ne_r5: assert property (@(posedge clk) disable iff (!rstN)
    (brType == 3'd2) && (rsIdx == rtIdx) |-> !taken);

  p_no_branch_r8: assert property (@(posedge clk) disable iff (!rstN)
    (brType == 3'd0) || (brType == 3'd7) |-> !taken);

endmodule

bind delay_branch_npc npc_checker #(
  .ADDR_W    (ADDR_W),
  .REG_IDX_W (REG_IDX_W),
  .OFF_W     (OFF_W),
  .BOOT_ADDR (BOOT_ADDR)
) u_npc_checker (.*);

// File: tb/tb_delay_branch_npc.sv
`timescale 1ns/1ps
module tb_delay_branch_npc;

  localparam logic [31:0] BOOT = 32'hBFC0_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  brType = '0;
  logic [15:0] brOffset = '0;
  logic [4:0]  rsIdx = '0, rtIdx = '0, prevDest = '0;
  logic [31:0] rsData = '0, rtData = '0, prevResult = '0;
  logic        prevWrEn = 1'b0, prevIsLoad = 1'b0;
  logic [31:0] fetchAddr;
  logic        taken;

  int total = 0;
  int bad = 0;
  logic [31:0] modelPc;
  logic [31:0] fetchLog[$];

  always #2 clk = ~clk;

  delay_branch_npc dut (
    .clk(clk), .rstN(rstN), .brType(brType), .brOffset(brOffset),
    .rsIdx(rsIdx), .rtIdx(rtIdx), .rsData(rsData), .rtData(rtData),
    .prevWrEn(prevWrEn), .prevIsLoad(prevIsLoad), .prevDest(prevDest),
    .prevResult(prevResult), .fetchAddr(fetchAddr), .taken(taken)
  );

  function automatic logic [31:0] readOp(logic [4:0] idx, logic [31:0] fileVal);
    if (idx == 0) return 32'd0;
    if (prevWrEn && !prevIsLoad && prevDest == idx) return prevResult;
    return fileVal;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear();
    brType = 0; brOffset = 0; rsIdx = 0; rtIdx = 0; rsData = 0; rtData = 0;
    prevWrEn = 0; prevIsLoad = 0; prevDest = 0; prevResult = 0;
  endtask

  // inputs are already set at a falling edge; check, then advance one cycle
  task automatic tick(string tag);
    logic [31:0] a, b, expFetch;
    logic expTaken;
    int so;
    #1;
    a = readOp(rsIdx, rsData);
    b = readOp(rtIdx, rtData);
    case (brType)
      3'd1: expTaken = (a == b);
      3'd2: expTaken = (a != b);
      3'd3: expTaken = $signed(a) < 0;
      3'd4: expTaken = $signed(a) >= 0;
      3'd5: expTaken = $signed(a) <= 0;
      3'd6: expTaken = $signed(a) > 0;
      default: expTaken = 1'b0;
    endcase
    so = $signed(brOffset);
    expFetch = expTaken ? (modelPc - 32'd4 + 32'(so * 4)) : modelPc;
    check({tag, " taken"}, {31'd0, taken}, {31'd0, expTaken});
    check({tag, " fetchAddr"}, fetchAddr, expFetch);
    fetchLog.push_back(fetchAddr);
    @(posedge clk);
    modelPc = expFetch + 32'd4;
    @(negedge clk);
    clear();
  endtask

  initial begin
    #100000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    modelPc = BOOT;
    repeat (3) @(negedge clk);
    // R1: held in reset
    check("R1 reset fetchAddr", fetchAddr, BOOT);
    check("R1 reset taken", {31'd0, taken}, 32'd0);
    brType = 3'd1;  // even an always-true test stays quiet in reset
    #1 check("R1 reset gated taken", {31'd0, taken}, 32'd0);
    clear();
    @(negedge clk);
    rstN = 1'b1;
    tick("R1 first cycle");
    tick("R2 seq");
    tick("R2 seq");

    // R3/R5: equal operands, positive offset
    brType = 3'd1; brOffset = 16'd8; rsIdx = 5'd3; rtIdx = 5'd4;
    rsData = 32'h55; rtData = 32'h55;
    tick("R3 R5 eq taken");
    tick("R4 target plus four");
    tick("R4 continue");
    // R4: order branch, delay slot, target
    check("R4 order", fetchLog[$-2] - fetchLog[$-4], 32'(8*4 + 4));

    brType = 3'd1; rsIdx = 5'd3; rtIdx = 5'd4; rsData = 32'h1; rtData = 32'h2;
    tick("R5 eq not taken");
    brType = 3'd2; rsIdx = 5'd3; rtIdx = 5'd4; rsData = 32'h7; rtData = 32'h7;
    tick("R5 ne not taken");
    brType = 3'd2; brOffset = 16'hFFF0; rsIdx = 5'd3; rtIdx = 5'd4;
    rsData = 32'h7; rtData = 32'h9;
    tick("R3 R5 ne taken negative offset");
    tick("R4 after backward");

    // R6
    brType = 3'd3; brOffset = 16'd2; rsIdx = 5'd9; rsData = 32'h8000_0000;
    tick("R6 ltz taken");
    brType = 3'd3; rsIdx = 5'd9; rsData = 32'h0;
    tick("R6 ltz zero");
    brType = 3'd4; brOffset = 16'd5; rsIdx = 5'd9; rsData = 32'h0;
    tick("R6 gez zero taken");
    brType = 3'd4; rsIdx = 5'd9; rsData = 32'hFFFF_FFFF;
    tick("R6 gez negative");

    // R7
    brType = 3'd5; brOffset = 16'd3; rsIdx = 5'd9; rsData = 32'h0;
    tick("R7 lez zero taken");
    brType = 3'd5; rsIdx = 5'd9; rsData = 32'h1;
    tick("R7 lez positive");
    brType = 3'd6; rsIdx = 5'd9; rsData = 32'h0;
    tick("R7 gtz zero");
    brType = 3'd6; brOffset = 16'd1; rsIdx = 5'd9; rsData = 32'h4;
    tick("R7 gtz taken");

    // R8
    brType = 3'd0; rsIdx = 5'd1; rtIdx = 5'd1;
    tick("R8 none");
    brType = 3'd7; brOffset = 16'd9; rsIdx = 5'd2; rsData = 32'h8000_0000;
    tick("R8 unused code");

    // R9: bypass of previous ALU result
    brType = 3'd3; brOffset = 16'd4; rsIdx = 5'd6; rsData = 32'h10;
    prevWrEn = 1; prevDest = 5'd6; prevResult = 32'hFFFF_FFF0;
    tick("R9 bypass ltz taken");
    brType = 3'd3; rsIdx = 5'd6; rsData = 32'h10;
    prevWrEn = 1; prevDest = 5'd7; prevResult = 32'hFFFF_FFF0;
    tick("R9 dest mismatch");
    brType = 3'd1; brOffset = 16'd6; rsIdx = 5'd6; rtIdx = 5'd8;
    rsData = 32'h1; rtData = 32'h2A;
    prevWrEn = 1; prevDest = 5'd6; prevResult = 32'h2A;
    tick("R9 bypass eq taken");
    brType = 3'd2; rsIdx = 5'd6; rtIdx = 5'd8; rsData = 32'h2A; rtData = 32'h2A;
    prevWrEn = 0; prevDest = 5'd8; prevResult = 32'h3;
    tick("R9 no write enable");

    // R10: register zero
    brType = 3'd3; brOffset = 16'd2; rsIdx = 5'd0; rsData = 32'h8000_0000;
    tick("R10 zero reg ignores file");
    brType = 3'd3; rsIdx = 5'd0;
    prevWrEn = 1; prevDest = 5'd0; prevResult = 32'h8000_0000;
    tick("R10 zero reg no bypass");
    brType = 3'd5; brOffset = 16'd3; rsIdx = 5'd0; rsData = 32'h5;
    tick("R10 lez zero reg taken");

    // R11: load result not forwarded
    brType = 3'd3; brOffset = 16'd2; rsIdx = 5'd12; rsData = 32'h1;
    prevWrEn = 1; prevIsLoad = 1; prevDest = 5'd12; prevResult = 32'h8000_0000;
    tick("R11 load not bypassed");
    brType = 3'd4; brOffset = 16'd2; rsIdx = 5'd12; rsData = 32'h1;
    prevWrEn = 1; prevIsLoad = 1; prevDest = 5'd12; prevResult = 32'h8000_0000;
    tick("R11 load old value gez taken");
    tick("R2 seq tail");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule